// File: doc/BRIEF.md
# Completion Code Interrupt Pending Logic

This block records transfer-completion events for a DMA controller. Each event carries a 6-bit completion code, a valid strobe and an enable qualifier. Events come from two independent sources: a normal-completion path and an early-completion path. An accepted code of value n sets bit n of a 64-bit pending set. That bit stays set until software clears it through a write-one-to-clear register.

Software sees the pending set as two 32-bit read-only words on a small register bus. Two further 32-bit words take the clear writes. The block has one interrupt output, which pulses for a single cycle when the pending set leaves the empty state. It stays quiet after that until software has drained every pending bit. This lets software collect a whole batch of completions from one interrupt.

Top module: `cc_pend_irq`

## Requirements
- R1: After reset, both pending words read 0 and `irq` is low.
- R2: An event from either source is taken only when its valid and its enable qualifier are both high in the same cycle. If the qualifier is low, the event changes nothing.
- R3: An accepted code n sets pending bit n one clock edge later. Codes 0..31 appear at bit n of the low pending word (address 0). Codes 32..63 appear at bit n-32 of the high pending word (address 1).
- R4: A set pending bit stays set until it is cleared. Later events with other codes leave it unchanged.
- R5: A write to the low clear word (address 2) or the high clear word (address 3) clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R6: The pending words are read-only. A write to address 0 or 1 has no effect.
- R7: When the pending set goes from empty to non-empty, `irq` is high for exactly the one cycle that follows the setting edge. No further pulse occurs while any pending bit is still set.
- R8: Once a clear empties the pending set, the next accepted event pulses `irq` again. This includes an event that lands in the same cycle as the final clear, which gives a pulse in the next cycle.
- R9: If an event sets a bit in the same cycle that a clear write targets that bit, the bit ends up set.
- R10: When both sources present accepted codes in the same cycle, both bits are set.
- R11: A read of address 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nrm_vld | input | 1 | Normal-completion event valid |
| nrm_code | input | 6 | Normal-completion code |
| nrm_en | input | 1 | Normal-completion interrupt qualifier |
| erl_vld | input | 1 | Early-completion event valid |
| erl_code | input | 6 | Early-completion code |
| erl_en | input | 1 | Early-completion interrupt qualifier |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 low pending, 1 high pending, 2 low clear, 3 high clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected for a read |
| irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The mapping is tried with codes at both ends of each word (0, 31, 32 and 63) and with mid-range codes from each source. This separates the low/high word split from the bit ordering within a word. The clear tests use partial masks, all-zero masks and full masks, so that a clear which affects too many bits or too few bits fails a check. Same-cycle cases drive events from both sources together and pair a set with a clear on the same bit. They also pair a new set with the final clear, which checks both set priority and the re-arm pulse.

// File: rtl/cc_pend_irq.sv
module cc_pend_irq #(
  parameter int CODE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nrm_vld,
  input  logic [CODE_W-1:0]         nrm_code,
  input  logic                      nrm_en,
  input  logic                      erl_vld,
  input  logic [CODE_W-1:0]         erl_code,
  input  logic                      erl_en,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [1:0]                bus_addr,
  input  logic [(1<<CODE_W)/2-1:0]  bus_wdata,
  output logic [(1<<CODE_W)/2-1:0]  bus_rdata,
  output logic                      irq
);
  localparam int NBITS  = 1 << CODE_W;
  localparam int WORD_W = NBITS / 2;
  localparam logic [NBITS-1:0] ONE = {{(NBITS-1){1'b0}}, 1'b1};

  logic [NBITS-1:0] pend, set_vec, clr_vec, kept;
  logic             clr_wr;

  assign set_vec = ((nrm_vld && nrm_en) ? (ONE << nrm_code) : '0)
                 | ((erl_vld && erl_en) ? (ONE << erl_code) : '0);

  assign clr_wr  = bus_sel && bus_wr && bus_addr[1];
  assign clr_vec = !clr_wr    ? '0 :
                   bus_addr[0] ? {bus_wdata, {WORD_W{1'b0}}} :
                                 {{WORD_W{1'b0}}, bus_wdata};
  assign kept    = pend & ~clr_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= kept | set_vec;
      irq  <= (kept == '0) && (set_vec != '0);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        2'd0:    bus_rdata = pend[WORD_W-1:0];
        2'd1:    bus_rdata = pend[NBITS-1:WORD_W];
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pend & $past(pend)) == $past(pend))); // R4

  AST_CLR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && !nrm_vld && !erl_vld)
      |=> ((pend[WORD_W-1:0] & $past(bus_wdata)) == '0)); // R5

  AST_RO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr[1] && !nrm_vld && !erl_vld)
      |=> (pend == $past(pend))); // R6

  AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0)); // R7

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend != '0) && !clr_wr) |=> !irq); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_vld && nrm_en) |=> pend[$past(nrm_code)]); // R9

  AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1]) |-> (bus_rdata == '0)); // R11
endmodule

// File: tb/cc_pend_irq_tb.sv
module cc_pend_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nrm_vld = 0, nrm_en = 0, erl_vld = 0, erl_en = 0;
  logic [5:0]  nrm_code = 0, erl_code = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_pend_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .nrm_vld(nrm_vld), .nrm_code(nrm_code), .nrm_en(nrm_en),
    .erl_vld(erl_vld), .erl_code(erl_code), .erl_en(erl_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    nrm_vld = 0; nrm_en = 0; erl_vld = 0; erl_en = 0;
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  // one clock cycle with the given stimulus; returns just after the edge
  task automatic cyc(input logic nv, input logic [5:0] nc, input logic ne,
                     input logic ev, input logic [5:0] ec, input logic ee,
                     input logic wr, input logic [1:0] a, input logic [31:0] wd);
    nrm_vld = nv; nrm_code = nc; nrm_en = ne;
    erl_vld = ev; erl_code = ec; erl_en = ee;
    bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic nrm_evt(input logic [5:0] c);
    cyc(1, c, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic erl_evt(input logic [5:0] c);
    cyc(0, 0, 0, 1, c, 1, 0, 0, 0);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1; d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic clear_all();
    wr_reg(2'd2, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(2'd0, d); check("R1 low word after reset", d, 0);
    rd_reg(2'd1, d); check("R1 high word after reset", d, 0);
    check("R1 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_enable_gate();
    logic [31:0] d;
    cyc(1, 6'd5, 0, 1, 6'd40, 0, 0, 0, 0);
    check("R2 irq with qualifier low", {31'b0, irq}, 0);
    rd_reg(2'd0, d); check("R2 low word with qualifier low", d, 0);
    rd_reg(2'd1, d); check("R2 high word with qualifier low", d, 0);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    nrm_evt(6'd0);
    check("R7 pulse on first set", {31'b0, irq}, 1);
    rd_reg(2'd0, d); check("R3 code 0 low bit 0", d, 32'h1);
    @(posedge clk); #1;
    check("R7 pulse lasts one cycle", {31'b0, irq}, 0);
    nrm_evt(6'd31);
    check("R7 no refire while pending", {31'b0, irq}, 0);
    rd_reg(2'd0, d); check("R3 code 31 low bit 31", d, 32'h8000_0001);
    erl_evt(6'd32);
    rd_reg(2'd1, d); check("R3 code 32 high bit 0", d, 32'h1);
    erl_evt(6'd63);
    rd_reg(2'd1, d); check("R3 code 63 high bit 31", d, 32'h8000_0001);
    rd_reg(2'd0, d); check("R4 low word kept", d, 32'h8000_0001);
    clear_all();
    rd_reg(2'd0, d); check("R5 full clear low", d, 0);
    rd_reg(2'd1, d); check("R5 full clear high", d, 0);
  endtask

  task automatic t_clear_ro();
    logic [31:0] d;
    nrm_evt(6'd3);
    nrm_evt(6'd4);
    erl_evt(6'd45);
    wr_reg(2'd2, 32'h0000_0008);
    rd_reg(2'd0, d); check("R5 partial clear low", d, 32'h10);
    check("R7 no pulse on partial clear", {31'b0, irq}, 0);
    wr_reg(2'd2, 32'h0);
    rd_reg(2'd0, d); check("R5 zero write keeps low", d, 32'h10);
    wr_reg(2'd3, 32'hFFFF_DFFF);
    rd_reg(2'd1, d); check("R5 masked clear high", d, 32'h2000);
    wr_reg(2'd0, 32'hFFFF_FFFF);
    wr_reg(2'd1, 32'h0);
    rd_reg(2'd0, d); check("R6 write to low pending ignored", d, 32'h10);
    rd_reg(2'd1, d); check("R6 write to high pending ignored", d, 32'h2000);
    rd_reg(2'd2, d); check("R11 low clear reads zero", d, 0);
    rd_reg(2'd3, d); check("R11 high clear reads zero", d, 0);
    wr_reg(2'd3, 32'h2000);
    wr_reg(2'd2, 32'h10);
    check("R8 no pulse on drain", {31'b0, irq}, 0);
    rd_reg(2'd0, d); check("R5 drained low", d, 0);
    nrm_evt(6'd7);
    check("R8 pulse after drain", {31'b0, irq}, 1);
    clear_all();
  endtask

  task automatic t_final_clear_set();
    logic [31:0] d;
    nrm_evt(6'd10);
    check("R7 pulse for code 10", {31'b0, irq}, 1);
    @(posedge clk); #1;
    cyc(0, 0, 0, 1, 6'd50, 1, 1, 2'd2, 32'h400);
    check("R8 pulse when set meets final clear", {31'b0, irq}, 1);
    rd_reg(2'd0, d); check("R8 low drained", d, 0);
    rd_reg(2'd1, d); check("R8 new high bit", d, 32'h0004_0000);
    clear_all();
  endtask

  task automatic t_collision();
    logic [31:0] d;
    nrm_evt(6'd12);
    @(posedge clk); #1;
    cyc(1, 6'd12, 1, 0, 0, 0, 1, 2'd2, 32'h1000);
    rd_reg(2'd0, d); check("R9 set beats clear", d, 32'h1000);
    wr_reg(2'd2, 32'h1000);
    cyc(0, 0, 0, 1, 6'd33, 1, 1, 2'd3, 32'h0000_0002);
    rd_reg(2'd1, d); check("R9 set beats clear high", d, 32'h2);
    clear_all();
  endtask

  task automatic t_dual();
    logic [31:0] d;
    cyc(1, 6'd2, 1, 1, 6'd33, 1, 0, 0, 0);
    check("R7 single pulse for dual set", {31'b0, irq}, 1);
    rd_reg(2'd0, d); check("R10 normal source bit", d, 32'h4);
    rd_reg(2'd1, d); check("R10 early source bit", d, 32'h2);
    @(posedge clk); #1;
    check("R7 dual pulse ends", {31'b0, irq}, 0);
    cyc(1, 6'd9, 1, 1, 6'd9, 1, 0, 0, 0);
    rd_reg(2'd0, d); check("R10 same code both sources", d, 32'h204);
    clear_all();
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_enable_gate();
    t_mapping();
    t_clear_ro();
    t_final_clear_set();
    t_collision();
    t_dual();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule